// File: doc/BRIEF.md
# Six-Pin Bidirectional General-Purpose I/O Port

This block puts six general-purpose pins behind a small register bus. Two registers are held inside: an output latch that holds the level each pin drives, and a direction register that decides, pin by pin, whether the tri-state driver is on. Every pin driver appears at the ports as a data-out line and an output-enable line. A pad is driven only while its enable is 1 and is left floating while its enable is 0.

Reading the port register returns the pin levels. These levels pass first through a two-flop synchronizer so that pins moving with no relation to the clock settle before they reach the bus. Reading the direction register returns its contents. Pin 3 can only ever be an input: its direction bit can be stored and read back, but its driver is never enabled. Software writes a direction bit of 0 to make a pin an output and 1 to make it an input.

The bus is a single write strobe with a two-bit address. A write lands on the rising clock edge at which the strobe is high. Reads are combinational from the selected address. The address decode is a four-entry enumeration: PORT (0), DIR (1) and two reserved entries (2, 3). The block has no sequencing states.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 6'b111111, the output latch (pad_out) is 0 and every pad_oe bit is 0.
- R2: A write with bus_wr high and bus_addr 1 loads bus_wdata[5:0] into the direction register at that clock edge. A read at bus_addr 1 returns the direction register on bus_rdata[5:0] with bus_rdata[7:6] at 0.
- R3: A write with bus_wr high and bus_addr 0 loads bus_wdata[5:0] into the output latch at that clock edge. pad_out always equals the output latch.
- R4: For every pin i other than 3, pad_oe[i] is 1 exactly when direction bit i is 0, where 0 means output and 1 means input.
- R5: pad_oe[3] is never 1, whatever direction bit 3 holds.
- R6: A read at bus_addr 0 returns on bus_rdata[5:0] the value pin_in had before the second-to-last rising edge, which is two register stages of delay. bus_rdata[7:6] is 0.
- R7: A cycle with bus_wr low changes no register. Writes at bus_addr 2 or 3 change no register. Reads at bus_addr 2 or 3 return 0.
- R8: A write to the port register leaves the direction register unchanged, and a write to the direction register leaves the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register select: 0 port, 1 direction, 2 and 3 reserved |
| bus_wdata | input | 8 | Write data; bits 5:0 are used |
| bus_rdata | output | 8 | Read data for the selected address |
| pin_in | input | 6 | Levels sensed on the pads |
| pad_out | output | 6 | Level each driver passes to its pad when enabled |
| pad_oe | output | 6 | Driver enable per pin; 0 leaves the pad floating |

## Verification
The bench uses the default values: six pins, pin 3 as the input-only pin, and two synchronizer stages. With these values, forcing an enable on pin 3 and the two-edge read latency can both be observed directly. Three behavioural quantities are tracked: the two latches and a two-entry pipeline of pin samples. They are compared on every cycle while directed sequences run (all pins set to output, writes with the strobe low, writes to reserved addresses, writes that alternate between registers) and then a long pseudo-random mix. A direction write of all zeros is the case where pin 3's enable would appear if the override were missing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT  = 2'd0,
        REG_DIR   = 2'd1,
        REG_RSVD2 = 2'd2,
        REG_RSVD3 = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS   = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   dir_q
);
    gpio_reg_e sel;
    logic      wr_port;
    logic      wr_dir;
    logic      wdata_hi_unused;

    assign sel             = gpio_reg_e'(addr);
    assign wr_port         = wr && (sel == REG_PORT);
    assign wr_dir          = wr && (sel == REG_DIR);
    assign wdata_hi_unused = ^wdata[DATA_W-1:PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '1;
        end else begin
            if (wr_port) out_q <= wdata[PINS-1:0];
            if (wr_dir)  dir_q <= wdata[PINS-1:0];
        end
    end
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int PINS    = 6,
    parameter int IN_ONLY = 3
) (
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] out_q,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);
    logic dir_fixed_unused;

    assign pad_out = out_q;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        if (i == IN_ONLY) begin : g_fixed_in
            assign pad_oe[i] = 1'b0;
        end else begin : g_bidir
            assign pad_oe[i] = ~dir_q[i];
        end
    end

    assign dir_fixed_unused = dir_q[IN_ONLY];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 6,
    parameter int DATA_W      = 8,
    parameter int IN_ONLY     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] pin_sync;
    gpio_reg_e       rd_sel;

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    gpio_drive #(.PINS(PINS), .IN_ONLY(IN_ONLY)) u_drive (
        .dir_q   (dir_q),
        .out_q   (out_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign rd_sel = gpio_reg_e'(bus_addr);

    always_comb begin
        bus_rdata = '0;
        unique case (rd_sel)
            REG_PORT:  bus_rdata[PINS-1:0] = pin_sync;
            REG_DIR:   bus_rdata[PINS-1:0] = dir_q;
            REG_RSVD2,
            REG_RSVD3: bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int PINS    = 6,
    parameter int DATA_W  = 8,
    parameter int IN_ONLY = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R5
    a_r5_fixed_input_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[IN_ONLY]);

    // R2, R4
    a_r4_dir_write_sets_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (pad_oe[0] == !$past(bus_wdata[0])));

    // R3
    a_r3_port_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (pad_out == $past(bus_wdata[PINS-1:0])));

    // R7, R8
    a_r7_oe_holds_without_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd1) |=> $stable(pad_oe));

    // R6
    a_r6_pin_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && bus_addr == 2'd0) |-> (bus_rdata[PINS-1:0] == $past(pin_in, 2)));

    // R7
    a_r7_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1]) |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .DATA_W(DATA_W), .IN_ONLY(IN_ONLY)) u_chk (.*);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [5:0] pin_in = 6'd0;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    int out_m, dir_m, s1, s2;
    int lfsr = 32'h1ACE;

    always #2 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int next_rand();
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
        return lfsr;
    endfunction

    // Drive one cycle, compare against the model, then advance the model at the edge.
    task automatic step(input bit wr, input int addr, input int wdata, input int pins, input string tag);
        int exp_rd;
        string rtag;
        @(negedge clk);
        bus_wr = wr; bus_addr = addr[1:0]; bus_wdata = wdata[7:0]; pin_in = pins[5:0];
        #1;
        if (addr == 0)      begin exp_rd = s2;    rtag = "R6"; end
        else if (addr == 1) begin exp_rd = dir_m; rtag = "R2"; end
        else                begin exp_rd = 0;     rtag = "R7"; end
        if (tag != "") rtag = tag;
        check(rtag, "bus_rdata", int'(bus_rdata), exp_rd);
        check("R3", "pad_out", int'(pad_out), out_m);
        check("R4", "pad_oe other pins", int'(pad_oe) & 6'h37, ~dir_m & 6'h37);
        check("R5", "pad_oe pin 3", int'(pad_oe[3]), 0);
        @(posedge clk);
        if (wr && addr == 0) out_m = wdata & 6'h3F;
        if (wr && addr == 1) dir_m = wdata & 6'h3F;
        s2 = s1;
        s1 = pins & 6'h3F;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        out_m = 0; dir_m = 6'h3F; s1 = 0; s2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        step(0, 1, 0, 0, "R1");
        check("R1", "pad_oe after reset", int'(pad_oe), 0);
        step(0, 0, 0, 0, "R1");

        // R2 / R4 / R5: every pin made an output
        step(1, 1, 8'h00, 0, "R2");
        step(0, 1, 0, 0, "R2");
        check("R5", "pad_oe with all dir 0", int'(pad_oe), 6'h37);
        // R3: output latch
        step(1, 0, 8'h3F, 0, "R3");
        step(1, 0, 8'h2A, 0, "R3");
        step(0, 0, 0, 0, "R3");
        check("R3", "pad_out latch", int'(pad_out), 6'h2A);
        // R2: upper data bits ignored
        step(1, 1, 8'hC5, 0, "R2");
        step(0, 1, 0, 0, "R2");
        // R7: strobe low and reserved addresses
        step(0, 1, 8'h12, 0, "R7");
        step(0, 0, 8'h0F, 0, "R7");
        step(1, 2, 8'h00, 0, "R7");
        step(1, 3, 8'h3F, 0, "R7");
        step(0, 2, 0, 0, "R7");
        step(0, 3, 0, 0, "R7");
        check("R7", "pad_out after ignored writes", int'(pad_out), 6'h2A);
        check("R7", "pad_oe after ignored writes", int'(pad_oe), 6'h32);
        // R8: cross-register independence
        step(1, 1, 8'h2A, 0, "R8");
        step(1, 0, 8'h15, 0, "R8");
        step(0, 1, 0, 0, "R8");
        check("R8", "pad_out after dir write", int'(pad_out), 6'h15);
        // R6: pin patterns through the synchronizer
        for (int k = 0; k < 12; k++) step(0, 0, 0, (k * 11 + 5) & 6'h3F, "R6");
        step(0, 0, 0, 6'h3F, "R6");
        step(0, 0, 0, 6'h00, "R6");
        step(0, 0, 0, 6'h00, "R6");
        step(0, 0, 0, 6'h00, "R6");
        // mixed pseudo-random traffic
        for (int k = 0; k < 400; k++) begin
            int r = next_rand();
            step(r[0], (r >> 1) & 3, (r >> 3) & 8'hFF, (r >> 7) & 6'h3F, "");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule